// File: doc/BRIEF.md
# Redundant Clock Count Monitor

This block watches a generated clock by comparing it against a trusted reference clock. One counter runs on the reference clock and serves as the golden count. Two more counters run on two redundant copies of the clock under test. Each test count leaves its own domain in Gray code, passes a two-flop synchronizer and is turned back into binary in the reference domain.

At the end of every fixed window of reference cycles the block takes the advance of each test count over the window. It subtracts the advance of the golden count from each and checks the result against a tolerance set at an input. If both copies are wrong in the same way, the clock generator itself is blamed. If only one copy is wrong, or the two copies disagree with each other, the path that carries the clock out is blamed.

Each fault is named stuck, glitch or drift. Each fault sets a sticky flag, bumps one of two saturating fail counters and writes an entry into a 16-deep circular log. The entry holds the fault class and kind, the synchronized lock and status bits of the generator, and a timestamp taken from the golden counter. A clear input resets the flag and both counters but leaves the log alone.

Top module: `clk_xcheck_mon`

## Requirements
- R1: After reset, `err_o` is 0, both fail counters are 0 and `log_wr_ptr_o` is 0.
- R2: The first window after reset only records a baseline. A window in which both copies advance within `tol_i` counts of the golden advance, and within `tol_i` of each other, reports nothing. This includes a single extra test-clock edge.
- R3: If both copies are out of tolerance (or advance zero) and agree with each other within `tol_i`, the window is a generator fault. `gen_fail_o` increments by one at the window's end, and the counters change at no other cycle.
- R4: If exactly one copy is out of tolerance, or the copies differ by more than `tol_i`, the window is a path fault and `path_fail_o` increments. At most one counter increments per window.
- R5: The fault kind is set as follows. If any failing copy advanced zero counts, the kind is stuck (0). Otherwise, if the previous compared window was clean, the kind is glitch (1). Otherwise the kind is drift (2).
- R6: A log entry is 21 bits wide. Bit [20] is 1 for a path fault and 0 for a generator fault. Bits [19:18] hold the kind, bit [17] the synchronized lock bit, bit [16] the synchronized status bit, and bits [15:0] the golden count just before the sampling edge. For the window ending at the k·W-th reference edge after reset, that count is k·W−1.
- R7: The log is a 16-entry circular buffer. Each fault writes at `log_wr_ptr_o`, the pointer advances by one modulo 16, the oldest entry is overwritten, and `log_rd_data_o` shows entry `log_rd_idx_i`.
- R8: `clear_i` zeroes `err_o` and both fail counters on the next edge. It leaves `log_wr_ptr_o` and the log contents unchanged.
- R9: `err_o` is sticky: once set it stays set until `clear_i` or reset.
- R10: Fail counters saturate at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Trusted reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset, all domains |
| tclk_a_i | input | 1 | First copy of the clock under test |
| tclk_b_i | input | 1 | Second copy of the clock under test |
| lock_i | input | 1 | Generator lock indication (asynchronous) |
| gen_status_i | input | 1 | Generator status bit logged with each fault (asynchronous) |
| tol_i | input | TOL_W | Allowed count deviation per window |
| clear_i | input | 1 | Clears sticky flag and fail counters |
| log_rd_idx_i | input | PTR_W | Log entry to read |
| err_o | output | 1 | Sticky fault flag |
| path_fail_o | output | FAIL_W | Path fault count |
| gen_fail_o | output | FAIL_W | Generator fault count |
| log_wr_ptr_o | output | PTR_W | Next log slot to be written |
| log_rd_data_o | output | ENT_W | Selected log entry |

## Verification
The bench drives the copies with the following patterns:
- both copies clean and in phase offset;
- both stopped, then restarted;
- one copy stopped, then restarted;
- both slowed to a longer period;
- a burst of five extra edges on one copy;
- a single extra edge on one copy.

Each pattern is timed against the sampling windows. A stop of both copies against a stop of one copy separates generator faults from path faults. The window that holds the stop edge, the full stopped windows and the window that holds the restart separate glitch, stuck and drift. The single extra edge probes the tolerance boundary. A long stop of one copy drives the fail counter into saturation and the log pointer around its wrap, after a clear whose effect on the log is checked.

// File: rtl/clk_xcheck_mon_pkg.sv
package clk_xcheck_mon_pkg;
  typedef enum logic [1:0] {
    KIND_STUCK  = 2'd0,
    KIND_GLITCH = 2'd1,
    KIND_DRIFT  = 2'd2
  } kind_e;
endpackage

// File: rtl/clk_xcheck_tcnt.sv
// Counter in a test-clock domain; publishes its value as registered Gray code.
module clk_xcheck_tcnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] gray_o
);
  logic [W-1:0] bin_q;
  logic [W-1:0] nxt;

  assign nxt = bin_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= nxt;
      gray_o <= nxt ^ (nxt >> 1);
    end
  end
endmodule

// File: rtl/clk_xcheck_gsync.sv
// Two-flop synchronizer for a Gray count, with conversion back to binary.
module clk_xcheck_gsync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) bin_o[i] = ^(s2_q >> i);
  end
endmodule

// File: rtl/clk_xcheck_classify.sv
// Judges one window: deviation of each copy from golden, and copy agreement.
module clk_xcheck_classify
  import clk_xcheck_mon_pkg::*;
#(
  parameter int W     = 16,
  parameter int TOL_W = 4
) (
  input  logic [W-1:0]     cur_a_i,
  input  logic [W-1:0]     prv_a_i,
  input  logic [W-1:0]     cur_b_i,
  input  logic [W-1:0]     prv_b_i,
  input  logic [W-1:0]     cur_g_i,
  input  logic [W-1:0]     prv_g_i,
  input  logic [TOL_W-1:0] tol_i,
  input  logic             prev_fault_i,
  output logic             fault_o,
  output logic             path_o,
  output kind_e            kind_o
);
  logic [W-1:0] da, db, dg;
  logic [W-1:0] mag_a, mag_b, mag_ab;
  logic [W-1:0] tol_w;
  logic         bad_a, bad_b, split;

  function automatic logic [W-1:0] mag(input logic [W-1:0] x);
    return x[W-1] ? (~x + 1'b1) : x;
  endfunction

  assign da     = cur_a_i - prv_a_i;
  assign db     = cur_b_i - prv_b_i;
  assign dg     = cur_g_i - prv_g_i;
  assign mag_a  = mag(da - dg);
  assign mag_b  = mag(db - dg);
  assign mag_ab = mag(da - db);
  assign tol_w  = W'(tol_i);

  assign bad_a = (da == '0) || (mag_a > tol_w);
  assign bad_b = (db == '0) || (mag_b > tol_w);
  assign split = mag_ab > tol_w;

  assign fault_o = bad_a | bad_b | split;
  assign path_o  = split | (bad_a ^ bad_b);

  always_comb begin
    if ((bad_a && da == '0) || (bad_b && db == '0)) kind_o = KIND_STUCK;
    else if (prev_fault_i)                          kind_o = KIND_DRIFT;
    else                                            kind_o = KIND_GLITCH;
  end
endmodule

// File: rtl/clk_xcheck_log.sv
// Circular capture log, written on each fault, read combinationally.
module clk_xcheck_log #(
  parameter int DEPTH = 16,
  parameter int EW    = 21,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [EW-1:0] wdata_i,
  input  logic [PW-1:0] rd_idx_i,
  output logic [EW-1:0] rdata_o,
  output logic [PW-1:0] wr_ptr_o
);
  logic [EW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_o <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[wr_ptr_o] <= wdata_i;
      wr_ptr_o        <= (wr_ptr_o == PW'(DEPTH - 1)) ? '0 : wr_ptr_o + 1'b1;
    end
  end

  assign rdata_o = mem_q[rd_idx_i];
endmodule

// File: rtl/clk_xcheck_mon.sv
module clk_xcheck_mon
  import clk_xcheck_mon_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int WIN_LOG2  = 10,
  parameter int TOL_W     = 4,
  parameter int FAIL_W    = 8,
  parameter int LOG_DEPTH = 16,
  parameter int TS_W      = 16,
  localparam int PTR_W    = $clog2(LOG_DEPTH),
  localparam int ENT_W    = TS_W + 5
) (
  input  logic             ref_clk_i,
  input  logic             rst_ni,
  input  logic             tclk_a_i,
  input  logic             tclk_b_i,
  input  logic             lock_i,
  input  logic             gen_status_i,
  input  logic [TOL_W-1:0] tol_i,
  input  logic             clear_i,
  input  logic [PTR_W-1:0] log_rd_idx_i,
  output logic             err_o,
  output logic [FAIL_W-1:0] path_fail_o,
  output logic [FAIL_W-1:0] gen_fail_o,
  output logic [PTR_W-1:0] log_wr_ptr_o,
  output logic [ENT_W-1:0] log_rd_data_o
);
  localparam int NCOPY = 2;

  logic [NCOPY-1:0] tclk;
  logic [CNT_W-1:0] cnt_gray [NCOPY];
  logic [CNT_W-1:0] cnt_bin  [NCOPY];
  logic [CNT_W-1:0] prv_q    [NCOPY];

  assign tclk = {tclk_b_i, tclk_a_i};

  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    clk_xcheck_tcnt #(.W(CNT_W)) u_tcnt (
      .clk_i (tclk[c]),
      .rst_ni(rst_ni),
      .gray_o(cnt_gray[c])
    );
    clk_xcheck_gsync #(.W(CNT_W)) u_sync (
      .clk_i (ref_clk_i),
      .rst_ni(rst_ni),
      .gray_i(cnt_gray[c]),
      .bin_o (cnt_bin[c])
    );
  end

  // Lock and status are asynchronous to the reference clock.
  logic [1:0] st_s1_q, st_s2_q;
  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_s1_q <= '0;
      st_s2_q <= '0;
    end else begin
      st_s1_q <= {lock_i, gen_status_i};
      st_s2_q <= st_s1_q;
    end
  end

  logic [WIN_LOG2-1:0] win_q;
  logic [CNT_W-1:0]    gold_q, gold_prv_q;
  logic                armed_q, prev_fault_q;
  logic                sample;

  assign sample = &win_q;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q        <= '0;
      gold_q       <= '0;
      gold_prv_q   <= '0;
      armed_q      <= 1'b0;
      prev_fault_q <= 1'b0;
      for (int c = 0; c < NCOPY; c++) prv_q[c] <= '0;
    end else begin
      win_q  <= win_q + 1'b1;
      gold_q <= gold_q + 1'b1;
      if (sample) begin
        gold_prv_q <= gold_q;
        armed_q    <= 1'b1;
        for (int c = 0; c < NCOPY; c++) prv_q[c] <= cnt_bin[c];
        if (armed_q) prev_fault_q <= fault;
      end
    end
  end

  logic  fault, is_path;
  kind_e kind;

  clk_xcheck_classify #(.W(CNT_W), .TOL_W(TOL_W)) u_cls (
    .cur_a_i     (cnt_bin[0]),
    .prv_a_i     (prv_q[0]),
    .cur_b_i     (cnt_bin[1]),
    .prv_b_i     (prv_q[1]),
    .cur_g_i     (gold_q),
    .prv_g_i     (gold_prv_q),
    .tol_i       (tol_i),
    .prev_fault_i(prev_fault_q),
    .fault_o     (fault),
    .path_o      (is_path),
    .kind_o      (kind)
  );

  logic hit;
  assign hit = sample & armed_q & fault;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o       <= 1'b0;
      path_fail_o <= '0;
      gen_fail_o  <= '0;
    end else if (clear_i) begin
      err_o       <= 1'b0;
      path_fail_o <= '0;
      gen_fail_o  <= '0;
    end else if (hit) begin
      err_o <= 1'b1;
      if (is_path && !(&path_fail_o)) path_fail_o <= path_fail_o + 1'b1;
      if (!is_path && !(&gen_fail_o)) gen_fail_o <= gen_fail_o + 1'b1;
    end
  end

  logic [ENT_W-1:0] entry;
  assign entry = {is_path, kind, st_s2_q[1], st_s2_q[0], TS_W'(gold_q)};

  clk_xcheck_log #(.DEPTH(LOG_DEPTH), .EW(ENT_W)) u_log (
    .clk_i   (ref_clk_i),
    .rst_ni  (rst_ni),
    .we_i    (hit),
    .wdata_i (entry),
    .rd_idx_i(log_rd_idx_i),
    .rdata_o (log_rd_data_o),
    .wr_ptr_o(log_wr_ptr_o)
  );
endmodule

module clk_xcheck_mon_chk #(
  parameter int FAIL_W = 8,
  parameter int PTR_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              sample_i,
  input logic              err_i,
  input logic [FAIL_W-1:0] path_fail_i,
  input logic [FAIL_W-1:0] gen_fail_i,
  input logic [PTR_W-1:0]  wr_ptr_i
);
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!err_i && path_fail_i == '0 && gen_fail_i == '0));

  assert_clear_keeps_log_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !sample_i) |=> $stable(wr_ptr_i));

  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !clear_i) |=> err_i);

  assert_only_at_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_i && !clear_i) |=> ($stable(path_fail_i) && $stable(gen_fail_i) && $stable(wr_ptr_i)));

  assert_one_class_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> !(path_fail_i != $past(path_fail_i) && gen_fail_i != $past(gen_fail_i)));

  assert_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (path_fail_i == $past(path_fail_i) ||
                  path_fail_i == FAIL_W'($past(path_fail_i) + 1'b1)));

  assert_ptr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |=> (wr_ptr_i == $past(wr_ptr_i) || wr_ptr_i == PTR_W'($past(wr_ptr_i) + 1'b1)));
endmodule

bind clk_xcheck_mon clk_xcheck_mon_chk #(.FAIL_W(FAIL_W), .PTR_W(PTR_W)) u_chk (
  .clk_i      (ref_clk_i),
  .rst_ni     (rst_ni),
  .clear_i    (clear_i),
  .sample_i   (sample),
  .err_i      (err_o),
  .path_fail_i(path_fail_o),
  .gen_fail_i (gen_fail_o),
  .wr_ptr_i   (log_wr_ptr_o)
);

// File: tb/tb_clk_xcheck_mon.sv
`timescale 1ns/100ps
module tb_clk_xcheck_mon;
  localparam int WL = 6;
  localparam int W  = 1 << WL;

  logic ref_clk = 1'b0;
  logic rst_n = 1'b0;
  logic tca = 1'b0, tcb = 1'b0, gla = 1'b0;
  logic run_a = 1'b1, run_b = 1'b1;
  real  ha = 2.5, hb = 2.5;
  logic lock = 1'b1, stat = 1'b0, clear = 1'b0;
  logic [3:0]  tol = 4'd2;
  logic [3:0]  rd_idx = '0;
  logic        err;
  logic [3:0]  pf, gf;
  logic [3:0]  wptr;
  logic [20:0] rdata;

  int checks = 0, fails = 0, edges = 0;

  clk_xcheck_mon #(.WIN_LOG2(WL), .FAIL_W(4)) dut (
    .ref_clk_i(ref_clk), .rst_ni(rst_n), .tclk_a_i(tca | gla), .tclk_b_i(tcb),
    .lock_i(lock), .gen_status_i(stat), .tol_i(tol), .clear_i(clear),
    .log_rd_idx_i(rd_idx), .err_o(err), .path_fail_o(pf), .gen_fail_o(gf),
    .log_wr_ptr_o(wptr), .log_rd_data_o(rdata)
  );

  always #2.5 ref_clk = ~ref_clk;
  initial begin #1.3; forever begin #(ha); if (run_a) tca = ~tca; end end
  initial begin #2.7; forever begin #(hb); if (run_b) tcb = ~tcb; end end
  always @(posedge ref_clk) if (rst_n) edges++;

  task automatic at_edge(input int n);
    while (edges < n) @(posedge ref_clk);
    @(negedge ref_clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_ent(input string tag, input int idx, input int p, input int k,
                         input int lk, input int st, input int ts);
    int exp;
    rd_idx = 4'(idx);
    #1;
    exp = (p << 20) | (k << 18) | (lk << 17) | (st << 16) | (ts & 16'hffff);
    chk(tag, int'(rdata), exp);
  endtask

  task automatic mid(input int k);
    at_edge(k * W + W / 2);
  endtask

  task automatic burst_a(input int n);
    repeat (n) begin
      @(negedge tca);
      #0.8 gla = 1'b1;
      #0.6 gla = 1'b0;
    end
  endtask

  initial begin
    fork
      begin
        #20; @(negedge ref_clk); rst_n = 1'b1;
        at_edge(2);
        chk("R1 err", err, 0); chk("R1 path", pf, 0);
        chk("R1 gen", gf, 0);  chk("R1 ptr", wptr, 0);
        // R2: clean windows, including baseline window
        at_edge(5 * W + 4);
        chk("R2 clean path", pf, 0); chk("R2 clean gen", gf, 0); chk("R2 clean err", err, 0);
        // R3/R5: both copies stop, then restart
        mid(5); lock = 1'b0; run_a = 1'b0; run_b = 1'b0;
        at_edge(6 * W + 4);
        chk("R3 gen first", gf, 1); chk("R9 err set", err, 1);
        mid(7); run_a = 1'b1; run_b = 1'b1;
        at_edge(8 * W + 4);
        chk("R3 gen", gf, 3); chk("R4 path none", pf, 0); chk("R7 ptr", wptr, 3);
        chk_ent("R5 R6 gen glitch", 0, 0, 1, 0, 0, 6 * W - 1);
        chk_ent("R5 R6 gen stuck",  1, 0, 0, 0, 0, 7 * W - 1);
        chk_ent("R5 R6 gen drift",  2, 0, 2, 0, 0, 8 * W - 1);
        mid(8); lock = 1'b1;
        // R4: one copy stops
        mid(9); stat = 1'b1;
        mid(10); run_b = 1'b0;
        mid(12); run_b = 1'b1;
        mid(13); stat = 1'b0;
        at_edge(14 * W + 4);
        chk("R4 path", pf, 3); chk("R4 gen kept", gf, 3); chk("R7 ptr2", wptr, 6);
        chk_ent("R4 R6 path glitch", 3, 1, 1, 1, 1, 11 * W - 1);
        chk_ent("R4 R6 path stuck",  4, 1, 0, 1, 1, 12 * W - 1);
        chk_ent("R4 R6 path drift",  5, 1, 2, 1, 1, 13 * W - 1);
        // R3/R5: both copies slowed
        mid(15); ha = 3.0; hb = 3.0;
        mid(16); ha = 2.5; hb = 2.5;
        at_edge(18 * W + 4);
        chk("R3 slow gen", gf, 5); chk("R3 slow path", pf, 3);
        chk_ent("R5 slow glitch", 6, 0, 1, 1, 0, 16 * W - 1);
        chk_ent("R5 slow drift",  7, 0, 2, 1, 0, 17 * W - 1);
        // R4: burst of extra edges on one copy
        mid(19); burst_a(5);
        at_edge(20 * W + 4);
        chk("R4 burst path", pf, 4);
        chk_ent("R4 burst entry", 8, 1, 1, 1, 0, 20 * W - 1);
        // R2: single extra edge within tolerance
        mid(21); burst_a(1);
        at_edge(22 * W + 4);
        chk("R2 tol path", pf, 4); chk("R2 tol ptr", wptr, 9);
        chk("R9 err sticky", err, 1);
        // R8: clear
        at_edge(23 * W + 10); clear = 1'b1;
        @(negedge ref_clk); clear = 1'b0;
        chk("R8 err", err, 0); chk("R8 path", pf, 0); chk("R8 gen", gf, 0);
        chk("R8 ptr kept", wptr, 9);
        chk_ent("R8 log kept", 0, 0, 1, 0, 0, 6 * W - 1);
        // R7/R10: long stop of one copy, wrap and saturation
        mid(24); run_b = 1'b0;
        mid(44); run_b = 1'b1;
        at_edge(45 * W + 4);
        chk("R10 saturate", pf, 15); chk("R7 wrap ptr", wptr, 14); chk("R3 gen none", gf, 0);
        chk_ent("R7 last entry",  13, 1, 2, 1, 0, 45 * W - 1);
        chk_ent("R7 overwritten", 0, 1, 0, 1, 0, 32 * W - 1);
      end
      begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule